// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block divides a slow tick into timed events. A 16-bit down counter steps once for each clock cycle in which the tick-enable input is high, and only while the timer is running. When the counter expires, the block sets a sticky flag. If the interrupt enable bit is set, the flag drives the interrupt output. In periodic mode the counter reloads itself and keeps running. In one-shot mode the timer stops itself.

Software sets the timer up through a byte-wide register port. A control byte holds the run, interrupt-enable, flag and mode bits, plus four upper bits that the timer only stores. Two byte registers hold the reload value. A count window shows the live counter, and any write to that window restarts the count. The tick runs at 32768 per second, so a reload of 0x8000 shifted right by n gives an event rate of 2^n per second.

Top module: `tick_timer`

## Requirements
- R1: After reset the control byte, both reload bytes and both count bytes read 0, and irq is low.
- R2: The control byte sits at offset 0x10. Bit 3 is run, bit 2 is interrupt enable, bit 1 is the event flag, and bit 0 is the mode (1 means periodic, 0 means one-shot). Bits 7 to 4 have no timer function and read back exactly as last written.
- R3: The reload value's low byte sits at 0x12 and its high byte at 0x13. Both read back as written, and writing them never changes a running count.
- R4: A write to the control byte that sets bit 3 while run is 0 loads the counter from the reload value. The count reads at 0x20 (low byte) and 0x21 (high byte).
- R5: While running, the count drops by one in every cycle with tickEn high. It does not change when tickEn is low or when run is 0.
- R6: A tick that arrives while the count is 1 or 0 is an expiry, and it sets the flag. With reload N (N at least 1), the flag is set by the Nth tick after a start.
- R7: In periodic mode an expiry reloads the counter from the reload value, and run stays set.
- R8: In one-shot mode an expiry clears run and leaves the count at 0.
- R9: Writing the control byte with bit 1 set clears the flag, and writing bit 1 as 0 leaves the flag unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R10: irq is high exactly when both the flag and the interrupt enable bit are set.
- R11: Any write to 0x20 or 0x21 reloads the counter from the reload value, whether or not the timer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | One-cycle tick qualifier from the 32768 per second source |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset for reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Interrupt request (flag AND interrupt enable) |

## Verification
Every register, count and flag change takes effect at the first rising edge that samples the write or tick, so each result can be read one cycle after its stimulus. Read data and irq are combinational from that state, so they can be observed in the same cycle the state changes. The bench drives each write or tick at a falling edge, removes it at the next falling edge, and then reads back half a cycle after the edge that acted on it. Tick-by-tick count values give the exact expiry cycle, including the cases where a clearing write and an expiry land on the same edge, or where a restart lands during a running count.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  // control byte bit positions
  localparam int unsigned BitMode = 0;
  localparam int unsigned BitFlag = 1;
  localparam int unsigned BitIen  = 2;
  localparam int unsigned BitRun  = 3;

  // register byte offsets
  localparam logic [7:0] OffCtl    = 8'h10;
  localparam logic [7:0] OffReload = 8'h12;
  localparam logic [7:0] OffCount  = 8'h20;

  typedef struct packed {
    logic restart;   // load counter from reload value
    logic step;      // count one tick
    logic relWr;     // a reload byte is being written
    logic periodic;  // reload on expiry
  } strobe_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expire,
  output strobe_t           strb,
  output logic [DATA_W-1:0] ctlQ
);
  localparam int NB = CNT_W / DATA_W;

  logic ctlWr, cntWr, relWr, startWr;
  logic [DATA_W-1:0] ctlNxt;

  always_comb begin
    cntWr = 1'b0;
    relWr = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (addr == ADDR_W'(OffCount) + ADDR_W'(i))  cntWr = wrEn;
      if (addr == ADDR_W'(OffReload) + ADDR_W'(i)) relWr = wrEn;
    end
  end

  assign ctlWr   = wrEn && (addr == ADDR_W'(OffCtl));
  assign startWr = ctlWr && wrData[BitRun] && !ctlQ[BitRun];

  always_comb begin
    strb.restart  = startWr || cntWr;
    strb.step     = ctlQ[BitRun] && tickEn && !strb.restart;
    strb.relWr    = relWr;
    strb.periodic = ctlQ[BitMode];
  end

  always_comb begin
    ctlNxt = ctlQ;
    if (ctlWr) begin
      ctlNxt          = wrData;
      ctlNxt[BitFlag] = ctlQ[BitFlag] & ~wrData[BitFlag];
    end
    if (expire) begin
      ctlNxt[BitFlag] = 1'b1;
      if (!ctlQ[BitMode] && !ctlWr) ctlNxt[BitRun] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctlQ <= '0;
    else       ctlQ <= ctlNxt;
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic              expire,
  output logic [CNT_W-1:0]  reloadQ,
  output logic [CNT_W-1:0]  countQ
);
  localparam int NB = CNT_W / DATA_W;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic laneHit;
    assign laneHit = strb.relWr && (addr == ADDR_W'(OffReload) + ADDR_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        reloadQ[g*DATA_W +: DATA_W] <= '0;
      else if (laneHit) reloadQ[g*DATA_W +: DATA_W] <= wrData;
    end
  end

  assign expire = strb.step && (countQ <= CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      countQ <= '0;
    else if (strb.restart)          countQ <= reloadQ;
    else if (expire)                countQ <= strb.periodic ? reloadQ : '0;
    else if (strb.step)             countQ <= countQ - CNT_W'(1);
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int NB = CNT_W / DATA_W;

  strobe_t           strb;
  logic              expire;
  logic [DATA_W-1:0] ctlQ;
  logic [CNT_W-1:0]  reloadQ;
  logic [CNT_W-1:0]  countQ;

  tick_timer_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .expire(expire), .strb(strb), .ctlQ(ctlQ)
  );

  tick_timer_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrData(wrData),
    .expire(expire), .reloadQ(reloadQ), .countQ(countQ)
  );

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(OffCtl)) rdData = ctlQ;
    for (int i = 0; i < NB; i++) begin
      if (addr == ADDR_W'(OffReload) + ADDR_W'(i)) rdData = reloadQ[i*DATA_W +: DATA_W];
      if (addr == ADDR_W'(OffCount) + ADDR_W'(i))  rdData = countQ[i*DATA_W +: DATA_W];
    end
  end

  assign irq = ctlQ[BitFlag] & ctlQ[BitIen];
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] ctlQ,
  input logic [CNT_W-1:0]  reloadQ,
  input logic [CNT_W-1:0]  countQ
);
  logic ctlWr;
  assign ctlWr = wrEn && (addr == ADDR_W'(OffCtl));

  p_start_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && wrData[BitRun] && !ctlQ[BitRun]) |=> (countQ == $past(reloadQ)) && ctlQ[BitRun]);

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && tickEn && ctlQ[BitRun] && countQ > CNT_W'(1)) |=> countQ == $past(countQ) - CNT_W'(1));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !tickEn) |=> $stable(countQ) && $stable(ctlQ));

  p_periodic_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && tickEn && ctlQ[BitRun] && ctlQ[BitMode] && countQ <= CNT_W'(1))
      |=> (countQ == $past(reloadQ)) && ctlQ[BitRun] && ctlQ[BitFlag]);

  p_oneshot_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && tickEn && ctlQ[BitRun] && !ctlQ[BitMode] && countQ <= CNT_W'(1))
      |=> (countQ == '0) && !ctlQ[BitRun] && ctlQ[BitFlag]);

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && wrData[BitFlag] && !tickEn) |=> !ctlQ[BitFlag]);
endmodule

bind tick_timer tick_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .ctlQ(ctlQ), .reloadQ(reloadQ), .countQ(countQ)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irq;
  int checks = 0;
  int fails = 0;

  tick_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    addr = a; #1;
    check(tag, {8'h00, rdData}, {8'h00, exp});
  endtask

  task automatic rdCount(input string tag, input logic [15:0] exp);
    logic [15:0] v;
    addr = 8'h20; #1; v[7:0] = rdData;
    addr = 8'h21; #1; v[15:8] = rdData;
    check(tag, v, exp);
  endtask

  task automatic checkIrq(input string tag, input logic exp);
    #1; check(tag, {15'd0, irq}, {15'd0, exp});
  endtask

  task automatic t_reset;
    rd("R1 ctl", 8'h10, 8'h00);
    rd("R1 reload lo", 8'h12, 8'h00);
    rd("R1 reload hi", 8'h13, 8'h00);
    rdCount("R1 count", 16'h0000);
    checkIrq("R1 irq", 1'b0);
  endtask

  task automatic t_regs;
    wr(8'h10, 8'hF0); rd("R2 upper bits", 8'h10, 8'hF0);
    wr(8'h10, 8'hF6); rd("R2 R9 flag write ignored", 8'h10, 8'hF4);
    wr(8'h10, 8'h02); rd("R2 back to zero", 8'h10, 8'h00);
    wr(8'h12, 8'h34); wr(8'h13, 8'h12);
    rd("R3 reload lo", 8'h12, 8'h34);
    rd("R3 reload hi", 8'h13, 8'h12);
  endtask

  task automatic t_periodic;
    wr(8'h12, 8'h03); wr(8'h13, 8'h00);
    wr(8'h10, 8'h0D); rdCount("R4 start load", 16'd3);
    tick(1); rdCount("R5 step", 16'd2);
    repeat (4) @(negedge clk);
    rdCount("R5 no tick hold", 16'd2);
    tick(1); rd("R6 no early flag", 8'h10, 8'h0D);
    tick(1);
    rd("R6 R7 flag run kept", 8'h10, 8'h0F);
    rdCount("R7 reload", 16'd3);
    checkIrq("R10 irq on", 1'b1);
    wr(8'h12, 8'h05); rdCount("R3 count untouched", 16'd3);
    wr(8'h10, 8'h0F); rd("R9 clear", 8'h10, 8'h0D);
    checkIrq("R10 irq off", 1'b0);
    rdCount("R9 no restart", 16'd3);
    wr(8'h10, 8'h09); tick(3);
    rd("R6 flag ien off", 8'h10, 8'h0B);
    checkIrq("R10 masked", 1'b0);
    rdCount("R7 new reload", 16'd5);
    wr(8'h10, 8'h0D); rd("R9 zero keeps flag", 8'h10, 8'h0F);
    checkIrq("R10 unmasked", 1'b1);
    wr(8'h10, 8'h02); rd("R9 stop", 8'h10, 8'h00);
  endtask

  task automatic t_oneshot;
    wr(8'h12, 8'h02); wr(8'h10, 8'h0C);
    rdCount("R4 oneshot load", 16'd2);
    tick(2);
    rd("R8 run cleared", 8'h10, 8'h06);
    rdCount("R8 count zero", 16'd0);
    checkIrq("R10 oneshot irq", 1'b1);
    tick(1); rdCount("R5 stopped", 16'd0);
    wr(8'h10, 8'h06); rd("R9 oneshot clear", 8'h10, 8'h04);
    wr(8'h10, 8'h00);
  endtask

  task automatic t_restart;
    wr(8'h12, 8'h04); wr(8'h10, 8'h0D);
    tick(2); rdCount("R5 two steps", 16'd2);
    wr(8'h20, 8'h00); rdCount("R11 restart", 16'd4);
    tick(3); rd("R6 not yet", 8'h10, 8'h0D);
    tick(1); rd("R6 fourth tick", 8'h10, 8'h0F);
    wr(8'h10, 8'h02);
    wr(8'h21, 8'h00); rdCount("R11 restart stopped", 16'd4);
  endtask

  task automatic t_collide;
    wr(8'h12, 8'h01); wr(8'h10, 8'h0D);
    tick(1); rd("R6 reload one", 8'h10, 8'h0F);
    @(negedge clk); wrEn = 1'b1; addr = 8'h10; wrData = 8'h0F; tickEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; tickEn = 1'b0;
    rd("R9 expiry wins", 8'h10, 8'h0F);
    wr(8'h10, 8'h02); rd("R9 final clear", 8'h10, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_periodic();
    t_oneshot();
    t_restart();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule